// File: doc/BRIEF.md
# CAN Interrupt Identifier Arbiter

This block collects every interrupt cause of a CAN controller into a single 16-bit identifier and one interrupt request line toward the CPU. It holds one pending flag for each of 32 message objects and one flag for the bus-status cause.

The message-handling logic and the bus-status logic raise these flags with one-cycle set strobes. Software lowers them through the register interface. Writing an object's pending bit to zero arrives here as a per-object clear strobe. Reading the status register arrives as a read strobe, and that read retires the status cause as a side effect.

The identifier always names the single most urgent cause, using a fixed ranking and ignoring arrival order. The request line follows the identifier, gated by a software-writable enable bit. Both outputs are registered. They reflect an event on the clock edge that samples it, so they are visible one cycle after the strobe.

Top module: `can_int_arbiter`

## Requirements
- R1: While `rst` is high on a clock edge, all pending flags, the enable bit, `int_id_o` and `irq_o` are cleared, whatever strobes are present.
- R2: With only message object k pending (k = 1..32, driven by bit k-1 of `obj_set_i`), `int_id_o` equals k, starting from the edge that samples the set strobe.
- R3: A pending status cause yields `int_id_o` = 0x8000 and outranks every pending message object.
- R4: Among pending message objects, the lowest object number is reported.
- R5: The reported cause depends only on which causes are pending, not on the order in which they became pending.
- R6: A cause stays pending until it is cleared. A clear strobe on an object that is not reported, or that is not pending, leaves the other causes and the identifier unchanged.
- R7: A pulse on `stat_rd_i` clears the status cause.
- R8: `irq_o` is 1 exactly when `int_id_o` is nonzero and the enable bit is 1.
- R9: When a set and a clear strike the same flag in the same cycle, the flag ends up set. This holds for objects and for the status cause.
- R10: When the reported cause is cleared, `int_id_o` moves to the next-highest pending cause on that same edge, with no further software action, or to 0x0000 when nothing remains.
- R11: The enable bit (`ie_o`) is written by `ie_we_i`/`ie_wdata_i` and resets to 0. Changing it never alters the pending flags or `int_id_o`.
- R12: `int_id_o` only ever takes the values 0x0000, 0x0001..0x0020, or 0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| obj_set_i | input | 32 | Per-object set strobes; bit k-1 is object k |
| obj_clr_i | input | 32 | Per-object clear strobes from software; bit k-1 is object k |
| stat_set_i | input | 1 | Status-cause set strobe from bus-status logic |
| stat_rd_i | input | 1 | Status register read strobe; clears the status cause |
| ie_we_i | input | 1 | Write strobe for the interrupt-enable bit |
| ie_wdata_i | input | 1 | Data for the interrupt-enable bit |
| ie_o | output | 1 | Current interrupt-enable bit |
| int_id_o | output | 16 | Identifier of the highest-priority pending cause |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The hardest situation to reach is the one where two events collide on one flag in the same cycle. This happens when software retires a cause at the moment hardware raises it again, or when the status register is read just as a new status event lands. Reaching it requires strobes that arrive together rather than in sequence. The stimulus table therefore drives set and clear on the same object, and set and read on the status cause, within a single vector. It also clears causes beneath the reported one, so that the fallback to the next cause is observed both with and without the enable bit.

// File: rtl/can_int_pkg.sv
package can_int_pkg;
  localparam int ID_W = 16;
  typedef logic [ID_W-1:0] int_id_t;
  localparam int_id_t ID_NONE   = '0;
  localparam int_id_t ID_STATUS = int_id_t'(16'h8000);
endpackage

// File: rtl/can_pend_bank.sv
// Bank of sticky pending flags; a set beats a clear on the same bit.
module can_pend_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] d_o
);
  assign d_o = (q_o & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_o;
  end

  // R9: a set strobe always leaves its flag high
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R6: flags without a strobe keep their value
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((q_o ^ $past(q_o)) & ~$past(set_i | clr_i)) == '0));
endmodule

// File: rtl/can_prio_enc.sv
// Finds the lowest set bit and reports it as a 1-based number.
module can_prio_enc #(
  parameter int W    = 32,
  parameter int ID_W = 16
) (
  input  logic [W-1:0]    vec_i,
  output logic            found_o,
  output logic [ID_W-1:0] num_o
);
  always_comb begin
    num_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) num_o = ID_W'(i + 1);
    end
  end

  assign found_o = |vec_i;

  // R4: a reported number points at a set bit
  always_comb begin
    if (found_o) p_num_valid_r4: assert (num_o != '0);
  end
endmodule

// File: rtl/can_int_arbiter.sv
module can_int_arbiter
  import can_int_pkg::*;
#(
  parameter int NOBJ = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NOBJ-1:0] obj_set_i,
  input  logic [NOBJ-1:0] obj_clr_i,
  input  logic            stat_set_i,
  input  logic            stat_rd_i,
  input  logic            ie_we_i,
  input  logic            ie_wdata_i,
  output logic            ie_o,
  output logic [ID_W-1:0] int_id_o,
  output logic            irq_o
);
  localparam int_id_t MAX_OBJ_ID = int_id_t'(NOBJ);

  logic [NOBJ-1:0] obj_q, obj_d;
  logic [0:0]      stat_q, stat_d;
  logic            obj_found;
  int_id_t         obj_num;
  int_id_t         id_next;
  logic            ie_next;

  can_pend_bank #(.W(NOBJ)) u_obj_bank (
    .clk(clk), .rst(rst), .set_i(obj_set_i), .clr_i(obj_clr_i),
    .q_o(obj_q), .d_o(obj_d)
  );

  can_pend_bank #(.W(1)) u_stat_bank (
    .clk(clk), .rst(rst), .set_i(stat_set_i), .clr_i(stat_rd_i),
    .q_o(stat_q), .d_o(stat_d)
  );

  // encode the flags as they will be after this edge
  can_prio_enc #(.W(NOBJ), .ID_W(ID_W)) u_enc (
    .vec_i(obj_d), .found_o(obj_found), .num_o(obj_num)
  );

  always_comb begin
    if (stat_d[0])      id_next = ID_STATUS;
    else if (obj_found) id_next = obj_num;
    else                id_next = ID_NONE;
  end

  assign ie_next = ie_we_i ? ie_wdata_i : ie_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_o     <= 1'b0;
      int_id_o <= ID_NONE;
      irq_o    <= 1'b0;
    end else begin
      ie_o     <= ie_next;
      int_id_o <= id_next;
      irq_o    <= ie_next && (id_next != ID_NONE);
    end
  end

  // R12: only legal identifier codes appear
  p_legal_code_r12: assert property (@(posedge clk) disable iff (rst)
    (int_id_o == ID_NONE) || (int_id_o == ID_STATUS) || (int_id_o <= MAX_OBJ_ID));

  // R8: request line tracks identifier and enable
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (ie_o && (int_id_o != ID_NONE)));

  // R3: a pending status cause is what gets reported
  p_status_top_r3: assert property (@(posedge clk) disable iff (rst)
    stat_q[0] |-> (int_id_o == ID_STATUS));

  // R6: identifier pointing at an object means that object is pending
  p_obj_pending_r6: assert property (@(posedge clk) disable iff (rst)
    ((int_id_o != ID_NONE) && (int_id_o != ID_STATUS)) |-> obj_q[int_id_o - 1]);

  // R11: enable writes alone never move the identifier
  p_ie_no_effect_r11: assert property (@(posedge clk) disable iff (rst)
    (obj_set_i == '0 && obj_clr_i == '0 && !stat_set_i && !stat_rd_i) |=> $stable(int_id_o));
endmodule

// File: tb/test_can_int_arbiter.sv
module test_can_int_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NOBJ = 32;
  localparam int NVEC = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NOBJ-1:0] obj_set = '0;
  logic [NOBJ-1:0] obj_clr = '0;
  logic            stat_set = 1'b0;
  logic            stat_rd = 1'b0;
  logic            ie_we = 1'b0;
  logic            ie_wd = 1'b0;
  logic            ie;
  logic [15:0]     int_id;
  logic            irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_int_arbiter #(.NOBJ(NOBJ)) i_can_int_arbiter (
    .clk(clk), .rst(rst), .obj_set_i(obj_set), .obj_clr_i(obj_clr),
    .stat_set_i(stat_set), .stat_rd_i(stat_rd), .ie_we_i(ie_we),
    .ie_wdata_i(ie_wd), .ie_o(ie), .int_id_o(int_id), .irq_o(irq)
  );

  // {oset[84:53], oclr[52:21], sset, srd, iwe, iwd, exp_id[16:1], exp_irq}
  localparam logic [84:0] VEC [NVEC] = '{
    {32'h0,        32'h0,        1'b0,1'b0,1'b1,1'b1, 16'h0000, 1'b0}, // R11 enable on
    {32'h10,       32'h0,        1'b0,1'b0,1'b0,1'b0, 16'h0005, 1'b1}, // R2 obj5
    {32'h2,        32'h0,        1'b0,1'b0,1'b0,1'b0, 16'h0002, 1'b1}, // R4 obj2 beats obj5
    {32'h0,        32'h0,        1'b1,1'b0,1'b0,1'b0, 16'h8000, 1'b1}, // R3 status on top
    {32'h0,        32'h10,       1'b0,1'b0,1'b0,1'b0, 16'h8000, 1'b1}, // R6 clear hidden obj5
    {32'h0,        32'h0,        1'b0,1'b1,1'b0,1'b0, 16'h0002, 1'b1}, // R7 R10 status read
    {32'h0,        32'h2,        1'b0,1'b0,1'b0,1'b0, 16'h0000, 1'b0}, // R10 all gone
    {32'h80000000, 32'h0,        1'b0,1'b0,1'b0,1'b0, 16'h0020, 1'b1}, // R2 obj32
    {32'h1,        32'h1,        1'b0,1'b0,1'b0,1'b0, 16'h0001, 1'b1}, // R9 set beats clear
    {32'h0,        32'h0,        1'b0,1'b0,1'b1,1'b0, 16'h0001, 1'b0}, // R8 R11 enable off
    {32'h0,        32'h1,        1'b0,1'b0,1'b0,1'b0, 16'h0020, 1'b0}, // R10 fallback masked
    {32'h0,        32'h0,        1'b0,1'b0,1'b1,1'b1, 16'h0020, 1'b1}, // R11 enable back on
    {32'h0,        32'h0,        1'b1,1'b1,1'b0,1'b0, 16'h8000, 1'b1}, // R9 status set beats read
    {32'h0,        32'h0,        1'b0,1'b1,1'b0,1'b0, 16'h0020, 1'b1}, // R7 status read
    {32'h0,        32'h80000000, 1'b0,1'b0,1'b0,1'b0, 16'h0000, 1'b0}, // R10 empty
    {32'h0,        32'h200,      1'b0,1'b0,1'b0,1'b0, 16'h0000, 1'b0}  // R6 clear idle obj10
  };

  task automatic step(input logic [NOBJ-1:0] os, input logic [NOBJ-1:0] oc,
                      input logic ss, input logic sr, input logic we, input logic wd);
    @(negedge clk);
    obj_set = os; obj_clr = oc; stat_set = ss; stat_rd = sr; ie_we = we; ie_wd = wd;
    @(posedge clk);
    #1;
    obj_set = '0; obj_clr = '0; stat_set = 1'b0; stat_rd = 1'b0; ie_we = 1'b0; ie_wd = 1'b0;
  endtask

  task automatic check(input string req, input logic [15:0] exp_id, input logic exp_irq);
    n_chk++;
    if (int_id !== exp_id || irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: id=%h irq=%b expected id=%h irq=%b", req, int_id, irq, exp_id, exp_irq);
    end
  endtask

  task automatic check_ie(input string req, input logic exp_ie);
    n_chk++;
    if (ie !== exp_ie) begin
      n_bad++;
      $display("FAIL %s: ie=%b expected ie=%b", req, ie, exp_ie);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 16'h0000, 1'b0);
    check_ie("R1 reset enable", 1'b0);
    @(negedge clk); rst = 1'b0;

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      step(VEC[v][84:53], VEC[v][52:21], VEC[v][20], VEC[v][19], VEC[v][18], VEC[v][17]);
      check($sformatf("vector %0d", v), VEC[v][16:1], VEC[v][0]);
    end

    // R2: every object alone, enable is on
    for (int k = 0; k < NOBJ; k++) begin
      step(NOBJ'(1) << k, '0, 1'b0, 1'b0, 1'b0, 1'b0);
      check($sformatf("R2 object %0d", k + 1), 16'(k + 1), 1'b1);
      step('0, NOBJ'(1) << k, 1'b0, 1'b0, 1'b0, 1'b0);
      check($sformatf("R6 clear object %0d", k + 1), 16'h0000, 1'b0);
    end

    // R5: arrival order does not matter
    step(32'h40, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(32'h4, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 obj7 then obj3", 16'h0003, 1'b1);
    step('0, 32'h44, 1'b0, 1'b0, 1'b0, 1'b0);
    step(32'h4, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(32'h40, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 obj3 then obj7", 16'h0003, 1'b1);
    step('0, 32'h44, 1'b0, 1'b0, 1'b0, 1'b0);

    // R4 R10: all set, walk down from the lowest number
    step('1, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4 all objects", 16'h0001, 1'b1);
    step('0, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 next after obj1", 16'h0002, 1'b1);
    step('0, 32'h2, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 next after obj2", 16'h0003, 1'b1);
    step('0, '1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 status alone after mass clear", 16'h8000, 1'b1);
    step('0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 status read to empty", 16'h0000, 1'b0);

    // R1: reset with pending state and live strobes
    step(32'h4, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1; obj_set = 32'h8; stat_set = 1'b1;
    @(posedge clk); #1;
    obj_set = '0; stat_set = 1'b0;
    check("R1 mid-run reset", 16'h0000, 1'b0);
    check_ie("R1 mid-run reset enable", 1'b0);
    @(negedge clk); rst = 1'b0;
    step(32'h4, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1 R8 enable stays off after reset", 16'h0003, 1'b0);
    step('0, '0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R8 enable raises request", 16'h0003, 1'b1);
    check_ie("R11 enable readback", 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule